// File: doc/BRIEF.md
# Carrier Slot Address Decoder with Byte-Lane Adjustment

This block sits between a host bus and a set of plug-in module slots on a carrier. A host access arrives in one of three local windows: a window that reaches each module's I/O, identification and interrupt-acknowledge spaces, a window for 16-bit module memory, and a window for 8-bit module memory. The decoder works out which slot the access targets, which space inside the module it reaches and the offset within that space, then presents a single-cycle request to that slot.

The host can choose big-endian byte-lane ordering separately for the I/O/ID/INT window and the 16-bit memory window. In that mode a byte access has address bit 0 inverted before decoding, and a halfword access has its two bytes exchanged both on the way out (write data) and on the way back (read data). The 8-bit memory window never applies this adjustment. Slots with no module fitted are never requested: reads from them return zero and writes to them are dropped.

Slot selection, space selection and write data are combinational from the request. The slot returns its read data in the same cycle, and the adjusted result is registered and reported to the host one clock later.

Top module: `ipslot_decoder`

## Requirements
- R1: `req_win` selects the window (0 = I/O/ID/INT, 1 = 16-bit memory, 2 = 8-bit memory); code 3 produces no slot request and a read returns 0. `req_size` is 0 for a byte and 1 for a halfword.
- R2: In window 0 the slot index is address bits [9:8]; address bits [7:6] equal to 2 give `slot_space` 1 (ID), equal to 3 give `slot_space` 2 (INT), and 0 or 1 give `slot_space` 0 (I/O).
- R3: In window 0 the offset is the address masked with 0x7F in I/O space and with 0x3F in ID or INT space.
- R4: In window 1 the slot index is address bits [24:23], the offset is address bits [22:0], and `slot_space` is 3.
- R5: In window 2 the slot index is address bits [23:22], the offset is address bits [21:0], `slot_space` is 4, halfword accesses are refused (no request, read 0), and no byte-lane adjustment is applied whatever `be_mode` holds.
- R6: `be_mode` bit 0 enables big-endian handling for window 0 and bit 1 for window 1; when enabled, a byte access inverts address bit 0 before the slot and offset are derived, and byte data passes unchanged.
- R7: When enabled, a halfword access exchanges the upper and lower byte of the write data sent to the slot and of the read data returned to the host; with the flag of the addressed window clear, data passes unchanged.
- R8: An access whose slot has its `slot_present` bit clear raises no `slot_req`, and a read from it returns 0.
- R9: A read request gives `rsp_valid` high in the next cycle with `rsp_rdata` holding the adjusted slot data of the request cycle; a write request gives `rsp_valid` low in the next cycle.
- R10: `slot_write` is high only together with `slot_req`; during reset `rsp_valid` and `rsp_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host access present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | 2 | Window select |
| req_addr | input | 25 | Address within the window |
| req_size | input | 1 | 0 = byte, 1 = halfword |
| req_wdata | input | 16 | Host write data |
| be_mode | input | 2 | Big-endian enables for windows 0 and 1 |
| slot_present | input | 4 | One bit per slot, set when a module is fitted |
| slot_req | output | 1 | Request to the selected slot |
| slot_write | output | 1 | Request is a write |
| slot_idx | output | 2 | Selected slot |
| slot_space | output | 3 | Space code inside the module |
| slot_off | output | 23 | Offset inside the space |
| slot_wdata | output | 16 | Write data after lane adjustment |
| slot_rdata | input | 16 | Read data returned by the selected slot |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 16 | Read data after lane adjustment |

## Verification
The registered read response of one access and the combinational decode of the next access share a cycle whenever requests come back to back. The bench provokes this by holding a big-endian halfword read in one cycle and replacing it at once with a write to a different window and slot; in the following cycle it judges `rsp_rdata` against the swapped data of the first access while `slot_idx`, `slot_space`, `slot_off` and `slot_wdata` are judged against the second. A response that leaked the second access's decode, or a decode held over from the first, shows as a mismatch on one side.

// File: rtl/ipslot_pkg.sv
`timescale 1ns/1ps
package ipslot_pkg;

   typedef enum logic [1:0] {
      WIN_IO   = 2'd0,
      WIN_M16  = 2'd1,
      WIN_M8   = 2'd2,
      WIN_NONE = 2'd3
   } win_t;

   typedef enum logic [2:0] {
      SP_IO  = 3'd0,
      SP_ID  = 3'd1,
      SP_INT = 3'd2,
      SP_M16 = 3'd3,
      SP_M8  = 3'd4
   } space_t;

   // window 0 sub-space field and offset masks
   localparam int IO_SEL_LSB = 6;
   localparam int IO_OFF_W   = 7;
   localparam int IDX_OFF_W  = 6;

endpackage

// File: rtl/ipslot_lane_swap.sv
`timescale 1ns/1ps
module ipslot_lane_swap #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int NB = DATA_W / 8;

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("ipslot_lane_swap: DATA_W must be a whole number of bytes");
      end
      for (genvar b = 0; b < NB; b++) begin : g_lane
         assign dout[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
      end
   endgenerate
endmodule

// File: rtl/ipslot_win_decode.sv
`timescale 1ns/1ps
module ipslot_win_decode
   import ipslot_pkg::*;
#(
   parameter int   ADDR_W   = 25,
   parameter int   SLOT_W   = 2,
   parameter int   OFF_W    = 23,
   parameter int   SLOT_LSB = 8,
   parameter win_t KIND     = WIN_IO
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [SLOT_W-1:0] slot,
   output space_t            space,
   output logic [OFF_W-1:0]  off
);
   generate
      if (SLOT_LSB + SLOT_W > ADDR_W) begin : g_bad_slot
         $error("ipslot_win_decode: slot field lies outside the address");
      end
      if (SLOT_LSB > OFF_W) begin : g_bad_off
         $error("ipslot_win_decode: offset port narrower than window offset");
      end
   endgenerate

   assign slot = addr[SLOT_LSB +: SLOT_W];

   generate
      if (KIND == WIN_IO) begin : g_io
         logic [1:0] sel;
         assign sel = addr[IO_SEL_LSB +: 2];
         always_comb begin
            case (sel)
               2'd2: begin
                  space = SP_ID;
                  off   = OFF_W'(addr[IDX_OFF_W-1:0]);
               end
               2'd3: begin
                  space = SP_INT;
                  off   = OFF_W'(addr[IDX_OFF_W-1:0]);
               end
               default: begin
                  space = SP_IO;
                  off   = OFF_W'(addr[IO_OFF_W-1:0]);
               end
            endcase
         end
      end else begin : g_mem
         assign space = (KIND == WIN_M16) ? SP_M16 : SP_M8;
         assign off   = OFF_W'(addr[SLOT_LSB-1:0]);
      end
   endgenerate
endmodule

// File: rtl/ipslot_decoder.sv
`timescale 1ns/1ps
module ipslot_decoder
   import ipslot_pkg::*;
#(
   parameter int ADDR_W  = 25,
   parameter int DATA_W  = 16,
   parameter int NSLOT   = 4,
   parameter int IO_LSB  = 8,
   parameter int M16_LSB = 23,
   parameter int M8_LSB  = 22,
   localparam int SLOT_W = $clog2(NSLOT),
   localparam int OFF_W  = M16_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_win,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        be_mode,
   input  logic [NSLOT-1:0]  slot_present,
   output logic              slot_req,
   output logic              slot_write,
   output logic [SLOT_W-1:0] slot_idx,
   output logic [2:0]        slot_space,
   output logic [OFF_W-1:0]  slot_off,
   output logic [DATA_W-1:0] slot_wdata,
   input  logic [DATA_W-1:0] slot_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   generate
      if (NSLOT != (1 << SLOT_W)) begin : g_bad_nslot
         $error("ipslot_decoder: NSLOT must be a power of two");
      end
      if (M8_LSB >= M16_LSB || IO_LSB >= M8_LSB) begin : g_bad_split
         $error("ipslot_decoder: window split points out of order");
      end
   endgenerate

   localparam int NWIN = 3;

   // ---------------- lane adjustment ----------------
   logic              be_act, flip_lo, swap_hw;
   logic [ADDR_W-1:0] addr_adj;
   logic [DATA_W-1:0] wdata_sw, rdata_sw, rd_now;

   always_comb begin
      case (req_win)
         WIN_IO:  be_act = be_mode[0];
         WIN_M16: be_act = be_mode[1];
         default: be_act = 1'b0;
      endcase
   end

   assign flip_lo  = be_act && !req_size;
   assign swap_hw  = be_act &&  req_size;
   assign addr_adj = req_addr ^ ADDR_W'(flip_lo);

   ipslot_lane_swap #(.DATA_W(DATA_W)) u_wswap (.din(req_wdata),  .dout(wdata_sw));
   ipslot_lane_swap #(.DATA_W(DATA_W)) u_rswap (.din(slot_rdata), .dout(rdata_sw));

   // ---------------- per-window decode ----------------
   logic [SLOT_W-1:0] w_slot  [NWIN];
   space_t            w_space [NWIN];
   logic [OFF_W-1:0]  w_off   [NWIN];

   ipslot_win_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
                       .SLOT_LSB(IO_LSB), .KIND(WIN_IO)) u_dec_io (
      .addr(addr_adj), .slot(w_slot[0]), .space(w_space[0]), .off(w_off[0]));

   ipslot_win_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
                       .SLOT_LSB(M16_LSB), .KIND(WIN_M16)) u_dec_m16 (
      .addr(addr_adj), .slot(w_slot[1]), .space(w_space[1]), .off(w_off[1]));

   ipslot_win_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .OFF_W(OFF_W),
                       .SLOT_LSB(M8_LSB), .KIND(WIN_M8)) u_dec_m8 (
      .addr(addr_adj), .slot(w_slot[2]), .space(w_space[2]), .off(w_off[2]));

   logic legal;
   always_comb begin
      slot_idx   = '0;
      slot_space = SP_IO;
      slot_off   = '0;
      legal      = 1'b0;
      case (req_win)
         WIN_IO: begin
            slot_idx = w_slot[0]; slot_space = w_space[0]; slot_off = w_off[0];
            legal    = 1'b1;
         end
         WIN_M16: begin
            slot_idx = w_slot[1]; slot_space = w_space[1]; slot_off = w_off[1];
            legal    = 1'b1;
         end
         WIN_M8: begin
            slot_idx = w_slot[2]; slot_space = w_space[2]; slot_off = w_off[2];
            legal    = !req_size;
         end
         default: legal = 1'b0;
      endcase
   end

   assign slot_req   = req_valid && legal && slot_present[slot_idx];
   assign slot_write = slot_req && req_write;
   assign slot_wdata = swap_hw ? wdata_sw : req_wdata;
   assign rd_now     = !slot_req ? '0 : (swap_hw ? rdata_sw : slot_rdata);

   // ---------------- registered read response ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         rsp_rdata <= (req_valid && !req_write) ? rd_now : '0;
      end
   end

   // ---------------- assertions ----------------
   // R8
   absent_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_req |-> slot_present[slot_idx]);

   // R8
   absent_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !slot_req) |=> (rsp_rdata == '0));

   // R10
   write_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_write |-> slot_req);

   // R3
   io_off_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && slot_space == SP_IO) |-> (slot_off[OFF_W-1:IO_OFF_W] == '0));

   // R3
   idint_off_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && (slot_space == SP_ID || slot_space == SP_INT))
         |-> (slot_off[OFF_W-1:IDX_OFF_W] == '0));

   // R5
   m8_byte_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_req && slot_space == SP_M8) |-> (!req_size && slot_off[OFF_W-1:M8_LSB] == '0));

   // R7
   swap_keeps_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      slot_write |-> ($countones(slot_wdata) == $countones(req_wdata)));

   // R9
   write_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write) |=> !rsp_valid);
endmodule

// File: tb/sim_ipslot_decoder.sv
`timescale 1ns/1ps
module sim_ipslot_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
   logic [1:0]  req_win = 2'd0, be_mode = 2'd0;
   logic [24:0] req_addr = '0;
   logic [15:0] req_wdata = '0, slot_rdata = '0;
   logic [3:0]  slot_present = 4'hF;
   logic        slot_req, slot_write, rsp_valid;
   logic [1:0]  slot_idx;
   logic [2:0]  slot_space;
   logic [22:0] slot_off;
   logic [15:0] slot_wdata, rsp_rdata;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   ipslot_decoder u0 (
      .clk, .rst_n, .req_valid, .req_write, .req_win, .req_addr, .req_size,
      .req_wdata, .be_mode, .slot_present, .slot_req, .slot_write, .slot_idx,
      .slot_space, .slot_off, .slot_wdata, .slot_rdata, .rsp_valid, .rsp_rdata);

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic [1:0]  win;
      logic [24:0] addr;
      logic        size;
      logic        wr;
      logic [15:0] wdata;
      logic [1:0]  be;
      logic [3:0]  pres;
      logic [15:0] srd;
      logic        e_req;
      logic [1:0]  e_idx;
      logic [2:0]  e_sp;
      logic [22:0] e_off;
      logic [15:0] e_wd;
      logic [15:0] e_rd;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t TAB [NV] = '{
      '{2'd0, 25'h0000145, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'hBEEF, 1'b1, 2'd1, 3'd0, 23'h000045, 16'h0000, 16'hBEEF},
      '{2'd0, 25'h00002A5, 1'b1, 1'b1, 16'h1234, 2'b00, 4'hF, 16'h0000, 1'b1, 2'd2, 3'd1, 23'h000025, 16'h1234, 16'h0000},
      '{2'd0, 25'h00003C2, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'h00AA, 1'b1, 2'd3, 3'd2, 23'h000002, 16'h0000, 16'h00AA},
      '{2'd0, 25'h000001F, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'h1111, 1'b1, 2'd0, 3'd0, 23'h00001F, 16'h0000, 16'h1111},
      '{2'd0, 25'h000017F, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'h2222, 1'b1, 2'd1, 3'd0, 23'h00007F, 16'h0000, 16'h2222},
      '{2'd0, 25'h00002FF, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'h3333, 1'b1, 2'd2, 3'd2, 23'h00003F, 16'h0000, 16'h3333},
      '{2'd1, 25'h1A34567, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'h5566, 1'b1, 2'd3, 3'd3, 23'h234567, 16'h0000, 16'h5566},
      '{2'd1, 25'h0800010, 1'b1, 1'b1, 16'hA1B2, 2'b10, 4'hF, 16'h0000, 1'b1, 2'd1, 3'd3, 23'h000010, 16'hB2A1, 16'h0000},
      '{2'd1, 25'h0000020, 1'b1, 1'b0, 16'h0000, 2'b10, 4'hF, 16'h1357, 1'b1, 2'd0, 3'd3, 23'h000020, 16'h0000, 16'h5713},
      '{2'd1, 25'h0000021, 1'b0, 1'b0, 16'h0000, 2'b10, 4'hF, 16'h0042, 1'b1, 2'd0, 3'd3, 23'h000020, 16'h0000, 16'h0042},
      '{2'd0, 25'h0000104, 1'b0, 1'b1, 16'h0077, 2'b01, 4'hF, 16'h0000, 1'b1, 2'd1, 3'd0, 23'h000005, 16'h0077, 16'h0000},
      '{2'd1, 25'h0000002, 1'b1, 1'b1, 16'hC0DE, 2'b01, 4'hF, 16'h0000, 1'b1, 2'd0, 3'd3, 23'h000002, 16'hC0DE, 16'h0000},
      '{2'd2, 25'h0C00005, 1'b0, 1'b0, 16'h0000, 2'b11, 4'hF, 16'h0099, 1'b1, 2'd3, 3'd4, 23'h000005, 16'h0000, 16'h0099},
      '{2'd2, 25'h0C00005, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'hFFFF, 1'b0, 2'd0, 3'd0, 23'h000000, 16'h0000, 16'h0000},
      '{2'd0, 25'h00002A5, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hB, 16'hFFFF, 1'b0, 2'd0, 3'd0, 23'h000000, 16'h0000, 16'h0000},
      '{2'd1, 25'h0800000, 1'b1, 1'b1, 16'h5A5A, 2'b00, 4'hD, 16'h0000, 1'b0, 2'd0, 3'd0, 23'h000000, 16'h0000, 16'h0000},
      '{2'd3, 25'h0000000, 1'b1, 1'b0, 16'h0000, 2'b00, 4'hF, 16'hFFFF, 1'b0, 2'd0, 3'd0, 23'h000000, 16'h0000, 16'h0000},
      '{2'd0, 25'h0000100, 1'b1, 1'b0, 16'h0000, 2'b01, 4'hF, 16'hABCD, 1'b1, 2'd1, 3'd0, 23'h000000, 16'h0000, 16'hCDAB}
   };

   function automatic string tag_of(int i);
      case (i)
         0, 3:     return "R2 io space";
         1:        return "R2 id space";
         2:        return "R2 int space";
         4, 5:     return "R3 offset mask";
         6:        return "R4 mem16 split";
         7, 17:    return "R7 halfword swap";
         8:        return "R7 read swap";
         9, 10:    return "R6 byte flip";
         11:       return "R7 per-window flag";
         12:       return "R5 mem8 no adjust";
         13:       return "R5 mem8 halfword refused";
         14, 15:   return "R8 absent slot";
         default:  return "R1 window none";
      endcase
   endfunction

   initial begin
      // R10 reset state
      #5;
      chk(rsp_valid == 1'b0, "R10 reset rsp_valid", 32'(rsp_valid), 0);
      chk(rsp_rdata == '0,   "R10 reset rsp_rdata", 32'(rsp_rdata), 0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         vec_t v;
         string t;
         v = TAB[i];
         t = tag_of(i);
         req_valid = 1'b1; req_win = v.win; req_addr = v.addr; req_size = v.size;
         req_write = v.wr; req_wdata = v.wdata; be_mode = v.be;
         slot_present = v.pres; slot_rdata = v.srd;
         #1;
         chk(slot_req == v.e_req, {t, " slot_req"}, 32'(slot_req), 32'(v.e_req));
         // R10 write strobe tracks request
         chk(slot_write == (v.e_req && v.wr), "R10 slot_write", 32'(slot_write),
             32'(v.e_req && v.wr));
         if (v.e_req) begin
            chk(slot_idx == v.e_idx,   {t, " slot_idx"},   32'(slot_idx),   32'(v.e_idx));
            chk(slot_space == v.e_sp,  {t, " slot_space"}, 32'(slot_space), 32'(v.e_sp));
            chk(slot_off == v.e_off,   {t, " slot_off"},   32'(slot_off),   32'(v.e_off));
            if (v.wr)
               chk(slot_wdata == v.e_wd, {t, " slot_wdata"}, 32'(slot_wdata), 32'(v.e_wd));
         end
         @(negedge clk);
         // R9 response timing
         chk(rsp_valid == !v.wr, "R9 rsp_valid", 32'(rsp_valid), 32'(!v.wr));
         if (!v.wr)
            chk(rsp_rdata == v.e_rd, {t, " rsp_rdata"}, 32'(rsp_rdata), 32'(v.e_rd));
         req_valid = 1'b0;
         @(negedge clk);
         chk(rsp_valid == 1'b0, "R9 idle no rsp", 32'(rsp_valid), 0);
      end

      // back to back: response of a read overlaps decode of a write
      slot_present = 4'hF;
      req_valid = 1'b1; req_write = 1'b0; req_win = 2'd1; req_size = 1'b1;
      req_addr = 25'h0800040; be_mode = 2'b10; slot_rdata = 16'h1357;
      @(negedge clk);
      req_write = 1'b1; req_win = 2'd0; req_addr = 25'h0000010; be_mode = 2'b00;
      req_wdata = 16'h2468; slot_rdata = 16'hFFFF;
      #1;
      chk(rsp_valid == 1'b1,     "R9 overlap rsp_valid",  32'(rsp_valid), 1);
      chk(rsp_rdata == 16'h5713, "R7 overlap rsp_rdata",  32'(rsp_rdata), 32'h5713);
      chk(slot_idx == 2'd0,      "R2 overlap slot_idx",   32'(slot_idx), 0);
      chk(slot_space == 3'd0,    "R2 overlap slot_space", 32'(slot_space), 0);
      chk(slot_off == 23'h10,    "R3 overlap slot_off",   32'(slot_off), 32'h10);
      chk(slot_wdata == 16'h2468,"R7 overlap slot_wdata", 32'(slot_wdata), 32'h2468);
      @(negedge clk);
      chk(rsp_valid == 1'b0,     "R9 write after read",   32'(rsp_valid), 0);
      req_valid = 1'b0;

      // R10 reset mid-run clears the response
      req_valid = 1'b1; req_write = 1'b0; req_win = 2'd0; req_addr = 25'h0;
      slot_rdata = 16'h7777;
      @(negedge clk);
      rst_n = 1'b0; req_valid = 1'b0;
      #1;
      chk(rsp_valid == 1'b0, "R10 reset clears valid", 32'(rsp_valid), 0);
      chk(rsp_rdata == '0,   "R10 reset clears data",  32'(rsp_rdata), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=%h exp=%h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule